// File: doc/BRIEF.md
# Floating-Point Sign Select

This unit picks one of two 64-bit data words according to the sign of a third word, read as an IEEE double. When the test word is greater than or equal to zero, the "pass" word is forwarded; in every other case, the "fail" word is forwarded. A NaN test word of either kind counts as "other", so it always forwards the fail word. Negative zero compares equal to zero, so it forwards the pass word.

The unit performs no arithmetic on the data words. It copies them bit for bit and raises no exception or status of any kind. This makes it a building block for branch-free min/max and for conditional assignment. For example, min(a,b) results from feeding a-b as the test word, b as the pass word and a as the fail word.

The result is registered. An input strobe qualifies each operation, and a matching output strobe follows one cycle later.

Top module: `fp_sign_select`

## Requirements
- R1: A test word that is not NaN and has its sign bit (bit 63) clear selects pass_op. This covers +0, positive denormals, positive normals and +infinity.
- R2: A test word of 0x8000000000000000 (negative zero) selects pass_op.
- R3: A test word is NaN when exponent bits 62:52 are all ones and fraction bits 51:0 are nonzero. Any NaN test word selects fail_op, whatever its sign bit and whatever its fraction bit 51 (quiet or signaling).
- R4: A test word with the sign bit set and bits 62:0 nonzero that is not NaN selects fail_op. This covers negative denormals, negative normals and -infinity.
- R5: The selected word appears on out_word bit-exactly, NaN payloads included.
- R6: out_valid is high exactly one cycle after each cycle with in_valid high, and the result of that input appears on out_word in the same cycle. Strobes that arrive back to back produce back-to-back results.
- R7: While in_valid is low, out_word keeps its last value and out_valid goes low one cycle later.
- R8: While rst_n is low, out_valid and out_word are zero one cycle after the next clock edge.
- R9: Feeding test=a-b, pass=b and fail=a yields min(a,b) for ordered, unequal operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the operands in this cycle |
| test_op | input | 64 | Double compared against zero |
| pass_op | input | 64 | Word forwarded when test_op >= 0 |
| fail_op | input | 64 | Word forwarded otherwise (including NaN) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_word | output | 64 | Selected word |

## Verification
Two things can happen in the same cycle: the unit accepts a new operand set, and it presents the result of the previous set. The vector table is streamed with in_valid held high continuously, so every cycle both captures a new test word and shows the prior selection. Each cycle's out_word is compared against the word that the previous cycle's test value should have chosen. To catch a select taken from the wrong cycle, the pass and fail words are changed from vector to vector and carry NaN payloads.

// File: rtl/fp_sign_select.sv
module fp_sign_select #(
  parameter int WIDTH = 64,
  parameter int EXP_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] test_op,
  input  logic [WIDTH-1:0] pass_op,
  input  logic [WIDTH-1:0] fail_op,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_word
);
  localparam int FRAC_W = WIDTH - 1 - EXP_W;

  logic sign_bit, exp_ones, frac_nz, mag_nz, is_nan, take_pass;

  assign sign_bit  = test_op[WIDTH-1];
  assign exp_ones  = &test_op[WIDTH-2 -: EXP_W];
  assign frac_nz   = |test_op[FRAC_W-1:0];
  assign mag_nz    = |test_op[WIDTH-2:0];
  assign is_nan    = exp_ones & frac_nz;
  assign take_pass = ~is_nan & (~sign_bit | ~mag_nz);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= take_pass ? pass_op : fail_op;
    end
  end
endmodule

// File: rtl/fp_sign_select_chk.sv
module fp_sign_select_chk #(
  parameter int WIDTH = 64,
  parameter int EXP_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [WIDTH-1:0] test_op,
  input logic [WIDTH-1:0] pass_op,
  input logic [WIDTH-1:0] fail_op,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_word
);
  localparam int FRAC_W = WIDTH - 1 - EXP_W;

  logic nan_c, neg_c, posz_c;
  always_comb begin
    nan_c  = (test_op[WIDTH-2:FRAC_W] == {EXP_W{1'b1}}) && (test_op[FRAC_W-1:0] != '0);
    neg_c  = test_op[WIDTH-1] && (test_op[WIDTH-2:0] != '0) && !nan_c;
    posz_c = !nan_c && !neg_c;
  end

  a_r1_r2_nonneg_pass: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && posz_c |=> out_word == $past(pass_op));
  a_r3_nan_to_fail: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && nan_c |=> out_word == $past(fail_op));
  a_r4_neg_to_fail: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && neg_c |=> out_word == $past(fail_op));
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r7_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word));
endmodule

bind fp_sign_select fp_sign_select_chk #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .test_op(test_op),
  .pass_op(pass_op), .fail_op(fail_op), .out_valid(out_valid), .out_word(out_word)
);

// File: tb/sim_fp_sign_select.sv
`timescale 1ns/1ps
module sim_fp_sign_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] test_op = '0, pass_op = '0, fail_op = '0;
  logic        out_valid;
  logic [63:0] out_word;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  fp_sign_select u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .test_op(test_op),
    .pass_op(pass_op), .fail_op(fail_op), .out_valid(out_valid), .out_word(out_word)
  );

  // {requirement number, 1 = pass_op expected, test word}
  localparam int NV = 12;
  localparam logic [68:0] VEC [NV] = '{
    {4'd1, 1'b1, 64'h3FF0000000000000},  // R1 +1.0
    {4'd1, 1'b1, 64'h0000000000000000},  // R1 +0
    {4'd2, 1'b1, 64'h8000000000000000},  // R2 -0
    {4'd1, 1'b1, 64'h7FF0000000000000},  // R1 +inf
    {4'd4, 1'b0, 64'hFFF0000000000000},  // R4 -inf
    {4'd3, 1'b0, 64'h7FF8000000000000},  // R3 quiet NaN
    {4'd3, 1'b0, 64'h7FF0000000000001},  // R3 signaling NaN
    {4'd3, 1'b0, 64'hFFF4000000000000},  // R3 negative signaling NaN
    {4'd1, 1'b1, 64'h0000000000000001},  // R1 +denormal
    {4'd4, 1'b0, 64'h8000000000000001},  // R4 -denormal
    {4'd4, 1'b0, 64'hBFF0000000000000},  // R4 -1.0
    {4'd1, 1'b1, 64'h7FEFFFFFFFFFFFFF}   // R1 largest finite
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_min(input real a, input real b);
    real m;
    m = (a < b) ? a : b;
    @(negedge clk);
    test_op = $realtobits(a - b); pass_op = $realtobits(b); fail_op = $realtobits(a);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 min", out_word, $realtobits(m));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic [63:0] exp_w;
    logic [3:0]  exp_r;
    repeat (3) @(negedge clk);
    check("R8 reset valid", {63'd0, out_valid}, 64'd0);
    check("R8 reset word", out_word, 64'd0);
    rst_n = 1'b1;

    // Streamed back to back: each cycle captures one vector and shows the previous
    exp_w = '0; exp_r = '0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check($sformatf("R%0d vec%0d", exp_r, i-1), out_word, exp_w);
        check("R6 stream valid", {63'd0, out_valid}, 64'd1);
      end
      test_op  = VEC[i][63:0];
      pass_op  = 64'h7FF8DEADBEEF0000 ^ 64'(i);   // R5 NaN payloads
      fail_op  = 64'hFFF0000000C0FF00 ^ 64'(i);
      in_valid = 1'b1;
      exp_w = VEC[i][64] ? pass_op : fail_op;
      exp_r = VEC[i][68:65];
    end
    @(negedge clk);
    in_valid = 1'b0;
    check($sformatf("R%0d vec%0d", exp_r, NV-1), out_word, exp_w);
    check("R5 payload exact", out_word, 64'h7FF8DEADBEEF000B);

    // R7: idle inputs change but the output holds
    test_op = 64'hBFF0000000000000; pass_op = 64'h1111; fail_op = 64'h2222;
    @(negedge clk);
    check("R7 valid low", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R7 word held", out_word, 64'h7FF8DEADBEEF000B);

    // R6 single strobe then R2 negative zero with distinct words
    test_op = 64'h8000000000000000; pass_op = 64'hA5A5A5A5A5A5A5A5; fail_op = 64'h5A5A5A5A5A5A5A5A;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 single valid", {63'd0, out_valid}, 64'd1);
    check("R2 neg zero", out_word, 64'hA5A5A5A5A5A5A5A5);

    // R9 min built from the select
    do_min(3.0, 5.0);
    do_min(5.0, 3.0);
    do_min(1.5, -7.25);
    do_min(-100.0, -0.5);

    // R8 reset with a strobe pending
    @(negedge clk);
    in_valid = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    check("R8 mid reset valid", {63'd0, out_valid}, 64'd0);
    check("R8 mid reset word", out_word, 64'd0);
    in_valid = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    summary();
  end
endmodule